// File: doc/BRIEF.md
# Register Write Retirement Queue

This block holds one in-order record for each architectural register write that the rename stage performs. Each record carries the physical register that the write displaced. When the write retires, that old physical register is no longer reachable, and the block hands its number back to the free list. Instructions arrive in groups of up to `LANES` per cycle. Each lane owns `WR_PER_LANE` write slots, and each slot is either in use or not. A lane whose slots are all unused is an instruction with no register destination, such as a store or a compare-and-branch. It costs nothing. An eliminated move still writes a register, so it takes a slot like any other write.

Allocation is a valid/ready stream. `alloc_ready` reflects the payload that is currently offered. It is high only when every enabled write slot fits into the free entries counted at the start of the cycle. A group that does not fit is held back whole, and the producer keeps it stable until a later cycle accepts it. The release side has no back-pressure. The retire logic states how many entries may retire, and the block emits up to that many old register numbers in the same cycle, each with its own strobe. A flush empties the queue and frees nothing.

Top module: `regwr_retire_queue`

## Requirements
- R1: Each set bit of `alloc_wr_en` in an accepted group takes exactly one entry. A lane with no set bits takes none. Bit `WR_PER_LANE*i+j` is write slot j of lane i.
- R2: Entries are released in allocation order. Within one group the order is by ascending bit index of `alloc_wr_en`, and slot k's old register is `alloc_old_preg[k*PREG_W +: PREG_W]`.
- R3: The queue holds at most `DEPTH` entries, 623 by default. When full, any group with at least one write is refused.
- R4: `alloc_ready` is high exactly when `flush` is low and the popcount of `alloc_wr_en` is no more than `DEPTH` minus occupancy. A group offered while `alloc_valid` is low, or while `alloc_ready` is low, adds nothing.
- R5: A `rel_count` above `REL_MAX` (16) releases only `REL_MAX` entries.
- R6: The number of entries released in a cycle is min(`rel_count`, `REL_MAX`, occupancy). Nothing is released beyond the newest entry.
- R7: Released entries appear on the low strobes, so `free_vld` is 2^n-1 for n releases. Slot k carries its register on `free_preg[k*PREG_W +: PREG_W]`, and a slot without a strobe reads zero.
- R8: While `flush` is high, `free_vld` is zero and `alloc_ready` is low. On the next cycle the queue is empty.
- R9: After reset the queue is empty. `free_vld` is zero and a full group of writes is accepted.
- R10: Free space is taken from the occupancy at the start of the cycle. Entries released in a cycle become usable on the next cycle, and allocation and release in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue without releasing entries |
| alloc_valid | input | 1 | An allocation group is offered |
| alloc_ready | output | 1 | The offered group fits and is taken this cycle |
| alloc_wr_en | input | LANES*WR_PER_LANE | Per-lane write-slot enables |
| alloc_old_preg | input | LANES*WR_PER_LANE*PREG_W | Displaced physical register for each slot |
| rel_count | input | $clog2(REL_MAX+1) | Number of entries allowed to retire this cycle |
| free_vld | output | REL_MAX | Strobe for each released slot |
| free_preg | output | REL_MAX*PREG_W | Freed physical register for each slot |

## Verification
Allocation is driven with several patterns. Sparse and mixed slot enables, including lanes with no writes, show whether entries are counted per write rather than per instruction and whether they are packed in bit order. Full sixteen-write groups that fill the queue exactly to capacity expose off-by-one faults in the fit test, and a zero-write group offered when full confirms that writeless instructions still pass. Release is driven with counts below, at and above the cap, and with counts larger than the occupancy, which tells clamping to the cap apart from clamping to the occupancy. A flush that arrives together with a pending release and allocation, followed by reuse of the ring, shows that the pointers restart cleanly.

// File: rtl/rwrq_pkg.sv
package rwrq_pkg;

  // Advance a ring index by inc with wrap at depth (inc < depth).
  function automatic int unsigned ring_add(int unsigned p, int unsigned inc,
                                           int unsigned depth);
    int unsigned s;
    s = p + inc;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/rwrq_alloc_pack.sv
module rwrq_alloc_pack #(
  parameter int NW    = 16,
  parameter int OFF_W = 5
) (
  input  logic [NW-1:0]       wr_en,
  output logic [OFF_W-1:0]    demand,
  output logic [NW*OFF_W-1:0] slot_off
);

  logic [OFF_W-1:0] run_c;

  // Exclusive prefix count: ring offset of each enabled write slot.
  always_comb begin
    run_c = '0;
    for (int b = 0; b < NW; b++) begin
      slot_off[b*OFF_W +: OFF_W] = run_c;
      run_c = run_c + OFF_W'(wr_en[b]);
    end
    demand = run_c;
  end

endmodule

// File: rtl/rwrq_ring.sv
module rwrq_ring #(
  parameter int DEPTH   = 623,
  parameter int PREG_W  = 10,
  parameter int NW      = 16,
  parameter int OFF_W   = 5,
  parameter int REL_MAX = 16,
  parameter int PTR_W   = 10
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [NW-1:0]             wr_en,
  input  logic [NW*PREG_W-1:0]      wr_data,
  input  logic [NW*OFF_W-1:0]       slot_off,
  input  logic [PTR_W-1:0]          tail,
  input  logic [PTR_W-1:0]          head,
  output logic [REL_MAX*PREG_W-1:0] rd_data
);

  logic [PREG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < NW; b++) begin
        if (wr_en[b])
          mem[PTR_W'(rwrq_pkg::ring_add(32'(tail), 32'(slot_off[b*OFF_W +: OFF_W]),
                                        DEPTH))] <= wr_data[b*PREG_W +: PREG_W];
      end
    end
  end

  for (genvar k = 0; k < REL_MAX; k++) begin : g_rd
    assign rd_data[k*PREG_W +: PREG_W] =
      mem[PTR_W'(rwrq_pkg::ring_add(32'(head), k, DEPTH))];
  end

endmodule

// File: rtl/rwrq_ctrl.sv
module rwrq_ctrl #(
  parameter int DEPTH   = 623,
  parameter int REL_MAX = 16,
  parameter int OFF_W   = 5,
  parameter int REL_W   = 5,
  parameter int PTR_W   = 10,
  parameter int CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_valid,
  input  logic [OFF_W-1:0] demand,
  input  logic [REL_W-1:0] rel_count,
  output logic             alloc_ready,
  output logic             fire,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [REL_W-1:0] n_rel
);

  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] space;
  logic [REL_W-1:0] rel_cap;
  logic [OFF_W-1:0] add_n;

  assign space       = CNT_W'(DEPTH) - occ;
  assign alloc_ready = !flush && (CNT_W'(demand) <= space);
  assign fire        = alloc_valid && alloc_ready;
  assign add_n       = fire ? demand : '0;

  always_comb begin
    rel_cap = (rel_count > REL_W'(REL_MAX)) ? REL_W'(REL_MAX) : rel_count;
    if (flush)                         n_rel = '0;
    else if (CNT_W'(rel_cap) <= occ)   n_rel = rel_cap;
    else                               n_rel = REL_W'(occ);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      head <= PTR_W'(rwrq_pkg::ring_add(32'(head), 32'(n_rel), DEPTH));
      tail <= PTR_W'(rwrq_pkg::ring_add(32'(tail), 32'(add_n), DEPTH));
      occ  <= occ + CNT_W'(add_n) - CNT_W'(n_rel);
    end
  end

endmodule

// File: rtl/regwr_retire_queue.sv
module regwr_retire_queue #(
  parameter int DEPTH       = 623,
  parameter int LANES       = 8,
  parameter int WR_PER_LANE = 2,
  parameter int PREG_W      = 10,
  parameter int REL_MAX     = 16,
  localparam int NW         = LANES * WR_PER_LANE,
  localparam int REL_W      = $clog2(REL_MAX + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      alloc_valid,
  output logic                      alloc_ready,
  input  logic [NW-1:0]             alloc_wr_en,
  input  logic [NW*PREG_W-1:0]      alloc_old_preg,
  input  logic [REL_W-1:0]          rel_count,
  output logic [REL_MAX-1:0]        free_vld,
  output logic [REL_MAX*PREG_W-1:0] free_preg
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OFF_W = $clog2(NW + 1);

  logic [OFF_W-1:0]          demand;
  logic [NW*OFF_W-1:0]       slot_off;
  logic                      fire;
  logic [PTR_W-1:0]          head, tail;
  logic [REL_W-1:0]          n_rel;
  logic [REL_MAX*PREG_W-1:0] rd_data;

  rwrq_alloc_pack #(.NW(NW), .OFF_W(OFF_W)) u_pack (
    .wr_en    (alloc_wr_en),
    .demand   (demand),
    .slot_off (slot_off)
  );

  rwrq_ctrl #(
    .DEPTH(DEPTH), .REL_MAX(REL_MAX), .OFF_W(OFF_W),
    .REL_W(REL_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .alloc_valid (alloc_valid),
    .demand      (demand),
    .rel_count   (rel_count),
    .alloc_ready (alloc_ready),
    .fire        (fire),
    .head        (head),
    .tail        (tail),
    .n_rel       (n_rel)
  );

  rwrq_ring #(
    .DEPTH(DEPTH), .PREG_W(PREG_W), .NW(NW), .OFF_W(OFF_W),
    .REL_MAX(REL_MAX), .PTR_W(PTR_W)
  ) u_ring (
    .clk      (clk),
    .we       (fire),
    .wr_en    (alloc_wr_en),
    .wr_data  (alloc_old_preg),
    .slot_off (slot_off),
    .tail     (tail),
    .head     (head),
    .rd_data  (rd_data)
  );

  for (genvar k = 0; k < REL_MAX; k++) begin : g_out
    assign free_vld[k] = REL_W'(k) < n_rel;
    assign free_preg[k*PREG_W +: PREG_W] =
      free_vld[k] ? rd_data[k*PREG_W +: PREG_W] : '0;
  end

endmodule

// File: rtl/rwrq_chk.sv
module rwrq_chk #(
  parameter int DEPTH   = 623,
  parameter int NW      = 16,
  parameter int REL_MAX = 16,
  parameter int REL_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               alloc_valid,
  input logic               alloc_ready,
  input logic [NW-1:0]      alloc_wr_en,
  input logic [REL_W-1:0]   rel_count,
  input logic [REL_MAX-1:0] free_vld
);

  // Independent occupancy tally built from port traffic only.
  int unsigned sh_occ;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) sh_occ <= 0;
    else sh_occ <= sh_occ
                   + ((alloc_valid && alloc_ready) ? 32'($countones(alloc_wr_en)) : 0)
                   - 32'($countones(free_vld));
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sh_occ <= DEPTH);

  a_r4_ready_fits: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready |-> (sh_occ + 32'($countones(alloc_wr_en)) <= DEPTH));

  a_r4_ready_when_room: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (sh_occ + 32'($countones(alloc_wr_en)) <= DEPTH)) |-> alloc_ready);

  a_r5_rel_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(free_vld) <= REL_MAX) && ($countones(free_vld) <= int'(rel_count)));

  a_r6_no_past_tail: assert property (@(posedge clk) disable iff (!rst_n)
    32'($countones(free_vld)) <= sh_occ);

  a_r7_low_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (free_vld & (free_vld + REL_MAX'(1))) == '0);

  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (free_vld == '0) && !alloc_ready);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> free_vld == '0);

endmodule

bind regwr_retire_queue rwrq_chk #(
  .DEPTH(DEPTH), .NW(NW), .REL_MAX(REL_MAX), .REL_W(REL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_wr_en (alloc_wr_en),
  .rel_count   (rel_count),
  .free_vld    (free_vld)
);

// File: tb/regwr_retire_queue_tb.sv
module regwr_retire_queue_tb;

  localparam int DEPTH = 623;
  localparam int NW    = 16;
  localparam int PW    = 10;
  localparam int RM    = 16;
  localparam int RW    = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              alloc_valid = 1'b0;
  logic              alloc_ready;
  logic [NW-1:0]     alloc_wr_en = '0;
  logic [NW*PW-1:0]  alloc_old_preg = '0;
  logic [RW-1:0]     rel_count = '0;
  logic [RM-1:0]     free_vld;
  logic [RM*PW-1:0]  free_preg;

  regwr_retire_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_wr_en(alloc_wr_en), .alloc_old_preg(alloc_old_preg),
    .rel_count(rel_count), .free_vld(free_vld), .free_preg(free_preg)
  );

  int q[$];
  int n_chk = 0;
  int n_bad = 0;
  int seq = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check before posedge, update model after it.
  task automatic cyc(string tag, logic v, logic [NW-1:0] en, int rel, logic fl);
    int dem, cap, n, room;
    bit rdy;
    @(negedge clk);
    alloc_valid = v;
    alloc_wr_en = en;
    for (int b = 0; b < NW; b++) begin
      alloc_old_preg[b*PW +: PW] = PW'((seq * 37 + 11) % 1024);
      seq++;
    end
    rel_count = RW'(rel);
    flush = fl;
    #2;
    dem  = $countones(en);
    room = DEPTH - q.size();
    rdy  = !fl && (dem <= room);
    chk({tag, " R4 alloc_ready"}, int'(alloc_ready), int'(rdy));
    cap = (rel > RM) ? RM : rel;
    n   = fl ? 0 : ((cap < q.size()) ? cap : q.size());
    chk({tag, " R6 release count"}, $countones(free_vld), n);
    chk({tag, " R7 strobe pattern"}, int'(free_vld), (1 << n) - 1);
    for (int k = 0; k < n; k++)
      chk({tag, " R2 released preg"}, int'(free_preg[k*PW +: PW]), q[k]);
    if (n < RM)
      chk({tag, " R7 idle slot zero"}, int'(free_preg[n*PW +: PW]), 0);
    @(posedge clk);
    #1;
    if (fl) q.delete();
    else begin
      for (int k = 0; k < n; k++) void'(q.pop_front());
      if (v && rdy)
        for (int b = 0; b < NW; b++)
          if (en[b]) q.push_back(int'(alloc_old_preg[b*PW +: PW]));
    end
  endtask

  task automatic drain(string tag);
    while (q.size() > 0) cyc(tag, 1'b0, '0, 16, 1'b0);
    cyc({tag, " empty"}, 1'b0, '0, 16, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R9 reset idle", 1'b0, '1, 16, 1'b0);
    chk("R9 queue empty after reset", q.size(), 0);
  endtask

  task automatic t_mixed();
    cyc("R1 writeless group", 1'b1, 16'h0000, 0, 1'b0);
    cyc("R1 sparse", 1'b1, 16'b0110_0001_0000_1011, 0, 1'b0);
    cyc("R4 not offered", 1'b0, 16'hFFFF, 0, 1'b0);
    cyc("R1 one per lane", 1'b1, 16'b0101_0101_0101_0101, 0, 1'b0);
    cyc("R1 release", 1'b0, '0, 16, 1'b0);
    drain("R1 drain");
  endtask

  task automatic t_order();
    cyc("R2 grp a", 1'b1, 16'hF00F, 3, 1'b0);
    cyc("R2 grp b", 1'b1, 16'h0A50, 3, 1'b0);
    cyc("R10 grp c", 1'b1, 16'h8001, 5, 1'b0);
    cyc("R2 partial", 1'b0, '0, 5, 1'b0);
    cyc("R6 over occupancy", 1'b0, '0, 16, 1'b0);
    drain("R2 drain");
  endtask

  task automatic t_cap();
    cyc("R5 fill a", 1'b1, 16'hFFFF, 0, 1'b0);
    cyc("R5 fill b", 1'b1, 16'hFFFF, 0, 1'b0);
    cyc("R5 rel 31", 1'b0, '0, 31, 1'b0);
    cyc("R5 rel 17", 1'b0, '0, 17, 1'b0);
    drain("R5 drain");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 38; i++) cyc("R3 fill", 1'b1, 16'hFFFF, 0, 1'b0);
    cyc("R3 to capacity", 1'b1, 16'h7FFF, 0, 1'b0);
    chk("R3 occupancy at capacity", q.size(), DEPTH);
    cyc("R3 full refuses one", 1'b1, 16'h0100, 0, 1'b0);
    cyc("R3 full takes writeless", 1'b1, 16'h0000, 0, 1'b0);
    cyc("R10 same-cycle release", 1'b1, 16'hFFFF, 16, 1'b0);
    cyc("R10 space next cycle", 1'b1, 16'hFFFF, 16, 1'b0);
    drain("R3 drain");
  endtask

  task automatic t_flush();
    cyc("R8 prefill", 1'b1, 16'h3C3C, 0, 1'b0);
    cyc("R8 prefill", 1'b1, 16'hFFFF, 0, 1'b0);
    cyc("R8 flush", 1'b1, 16'hFFFF, 16, 1'b1);
    cyc("R8 after flush", 1'b0, '0, 16, 1'b0);
    chk("R8 queue empty", q.size(), 0);
    cyc("R2 reuse", 1'b1, 16'h1234, 2, 1'b0);
    drain("R2 reuse drain");
  endtask

  initial begin
    t_reset();
    t_mixed();
    t_order();
    t_cap();
    t_fill();
    t_flush();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule